// File: doc/BRIEF.md
# Ping-Pong Traceback Survivor Manager

This block sits behind the add-compare-select array of a Viterbi decoder whose constraint length K can be changed while it runs, from 3 up to a parameter maximum. On every accepted trellis step the array supplies one survivor word, with one decision bit per trellis state. The block stores the whole word in a single location of a survivor bank. When a block of `DEPTH` steps has been stored, the bank is closed and handed to a traceback engine. The next block is written into the second bank while the first is read.

Traceback starts from the best state that the best-state finder supplies with the final step of the block, and walks back from the newest step to the oldest. At each step it recovers one decoded bit. These bits come out newest first, so each block's bits fill one of two small stacks and are then popped out oldest first. While one stack drains, the other fills. The result is a serial stream of decoded bits in transmission order. When steps arrive on every clock, the stream has no idle cycle between blocks.

Top module: `tbk_survivor_mgr`

## Requirements
- R1: While reset is high and afterwards, `dec_valid` stays low until a complete block of `DEPTH` steps has been accepted since reset and traced back. A block left partly written when reset rises produces no output.
- R2: A cycle with `step_valid` low stores nothing and does not advance the block. The values on `surv_word`, `best_state` and `k_len` in that cycle have no effect on the output.
- R3: Steps are counted into blocks of `DEPTH`. The banks swap roles after each block. The block's traceback starts from `best_state` as sampled together with the block's final step, and its decoded bits come out oldest step first.
- R4: Traceback rule. From state s at step t, the survivor bit is bit s of step t's word, and the decoded bit for step t is s[0]. The state for step t-1 is (s >> 1) with the survivor bit placed at bit position K-2.
- R5: Only the low K-1 bits of `best_state` and the low 2^(K-1) bits of each survivor word influence decoding. Higher bits are ignored.
- R6: K is sampled from `k_len` (its value is K itself) with the final step of each block and applies to that whole block. K may differ from one block to the next.
- R7: A `k_len` value below 3 is treated as K = 3, and a value above `KMAX` is treated as `KMAX`.
- R8: The first decoded bit of a block appears on the outputs `DEPTH`+3 clock edges after the edge that accepts the block's final step. Its `DEPTH` bits then follow on consecutive cycles.
- R9: With a step accepted on every clock, the decoded stream of consecutive blocks is continuous, with no idle cycle between blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | A survivor word for one trellis step is present |
| surv_word | input | 2^(KMAX-1) | Survivor decision bits, bit i for state i |
| best_state | input | KMAX-1 | Best (smallest-metric) state, used with a block's final step |
| k_len | input | clog2(KMAX+1) | Constraint length K, sampled with a block's final step |
| dec_valid | output | 1 | `dec_bit` carries a decoded bit this cycle |
| dec_bit | output | 1 | Decoded bit, in time order |

## Verification
A wrong internal state in this block is confined to one block of output. A bad traceback state or an off-by-one survivor selection corrupts decoded bits from the failing step back to the oldest step of that block. Those bits appear within `DEPTH`+3 to 2·`DEPTH`+3 cycles of the block's final step, so comparing against an independently encoded bit sequence exposes the fault in the very next burst. A bank-select or stack-select fault shows up as a whole block decoded from the wrong data, or as two blocks interleaved. A pointer fault changes the burst length or the cycle on which `dec_valid` first rises, so the tests check latency and gap-free bursts as well as bit values.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

  // Defaults shared by the survivor manager and its bench
  localparam int unsigned TBK_KMAX_DEF  = 7;
  localparam int unsigned TBK_DEPTH_DEF = 32;
  localparam int unsigned TBK_KMIN      = 3;

  // Bring a requested constraint length into the supported range
  function automatic int unsigned tbk_clamp_k(input int unsigned k, input int unsigned kmax);
    if (k < TBK_KMIN) return TBK_KMIN;
    if (k > kmax)     return kmax;
    return k;
  endfunction

endpackage

// File: rtl/tbk_bank.sv
// One survivor bank: one full survivor word per location, synchronous read
module tbk_bank #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tbk_tracer.sv
// Pipelined traceback: addresses run newest to oldest one per cycle,
// the state-dependent bit selection happens one cycle after the read.
module tbk_tracer #(
  parameter int unsigned KMAX  = 7,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned SW   = KMAX - 1,
  localparam int unsigned NS   = 1 << SW,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned KW   = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_bank,
  input  logic [SW-1:0] start_state,
  input  logic [KW-1:0] start_k,
  output logic [AW-1:0] raddr,
  input  logic [NS-1:0] rdata0,
  input  logic [NS-1:0] rdata1,
  output logic          push,
  output logic          push_bit,
  output logic          push_last,
  output logic          push_sel
);

  localparam logic [AW-1:0] NEWEST = AW'(DEPTH - 1);

  // Issue stage
  logic          a_act, a_first, a_bank;
  logic [AW-1:0] a_addr;
  logic [SW-1:0] a_start;
  logic [KW-1:0] a_k;
  // Data stage, aligned with the bank read data
  logic          b_act, b_first, b_last, b_bank;
  logic [SW-1:0] b_start;
  logic [KW-1:0] b_k;
  // Running trellis state
  logic [SW-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_act   <= 1'b0;
      a_first <= 1'b0;
      a_bank  <= 1'b0;
      a_addr  <= '0;
      a_start <= '0;
      a_k     <= '0;
    end else if (start) begin
      a_act   <= 1'b1;
      a_first <= 1'b1;
      a_bank  <= start_bank;
      a_addr  <= NEWEST;
      a_start <= start_state;
      a_k     <= start_k;
    end else if (a_act) begin
      a_first <= 1'b0;
      if (a_addr == '0) a_act <= 1'b0;
      else              a_addr <= a_addr - AW'(1);
    end
  end

  assign raddr = a_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_act   <= 1'b0;
      b_first <= 1'b0;
      b_last  <= 1'b0;
      b_bank  <= 1'b0;
      b_start <= '0;
      b_k     <= '0;
    end else begin
      b_act   <= a_act;
      b_first <= a_first;
      b_last  <= (a_addr == '0);
      b_bank  <= a_bank;
      b_start <= a_start;
      b_k     <= a_k;
    end
  end

  logic [SW-1:0] s_now, s_prev;
  logic [NS-1:0] word;
  logic          sbit;

  always_comb begin
    s_now  = b_first ? b_start : cur;
    word   = b_bank ? rdata1 : rdata0;
    sbit   = word[s_now];
    s_prev = (s_now >> 1) | (SW'(sbit) << (b_k - KW'(2)));
  end

  always_ff @(posedge clk) begin
    if (rst)        cur <= '0;
    else if (b_act) cur <= s_prev;
  end

  assign push      = b_act;
  assign push_bit  = s_now[0];
  assign push_last = b_last;
  assign push_sel  = b_bank;

  // The carried state never holds bits above position K-2
  assert_state_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (b_act && !b_first) |-> ((cur >> (b_k - KW'(1))) == '0));

endmodule

// File: rtl/tbk_lifo.sv
// Bit stack: filled newest-first by traceback, drained after the last push
module tbk_lifo #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_bit,
  input  logic push_last,
  output logic out_valid,
  output logic out_bit
);

  logic [DEPTH-1:0] stk;
  logic [PW-1:0]    sp;
  logic             draining;
  logic [AW-1:0]    wr_idx, rd_idx;

  assign wr_idx = sp[AW-1:0];
  assign rd_idx = AW'(sp - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      stk       <= '0;
      sp        <= '0;
      draining  <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (push) begin
        stk[wr_idx] <= push_bit;
        sp          <= sp + PW'(1);
        if (push_last) draining <= 1'b1;
      end else if (draining) begin
        out_bit   <= stk[rd_idx];
        out_valid <= 1'b1;
        sp        <= sp - PW'(1);
        if (sp == PW'(1)) draining <= 1'b0;
      end
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (sp < PW'(DEPTH)));

  assert_no_fill_while_drain_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> !draining);

endmodule

// File: rtl/tbk_survivor_mgr.sv
module tbk_survivor_mgr
  import tbk_pkg::*;
#(
  parameter int unsigned KMAX  = TBK_KMAX_DEF,
  parameter int unsigned DEPTH = TBK_DEPTH_DEF,
  localparam int unsigned SW   = KMAX - 1,
  localparam int unsigned NS   = 1 << SW,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned KW   = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_valid,
  input  logic [NS-1:0] surv_word,
  input  logic [SW-1:0] best_state,
  input  logic [KW-1:0] k_len,
  output logic          dec_valid,
  output logic          dec_bit
);

  localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);

  // Write side: location pointer and the bank being filled
  logic [AW-1:0] wr_ptr;
  logic          wr_bank;
  logic          blk_end;

  assign blk_end = step_valid && (wr_ptr == LAST_LOC);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      wr_bank <= 1'b0;
    end else if (step_valid) begin
      wr_ptr <= blk_end ? '0 : wr_ptr + AW'(1);
      if (blk_end) wr_bank <= ~wr_bank;
    end
  end

  // Constraint length for the closing block, and the masked start state
  logic [KW-1:0] k_eff;
  logic [SW-1:0] st_mask, start_state;

  always_comb begin
    k_eff       = KW'(tbk_clamp_k(int'(k_len), KMAX));
    st_mask     = {SW{1'b1}} >> (KW'(KMAX) - k_eff);
    start_state = best_state & st_mask;
  end

  // Two survivor banks
  logic [AW-1:0] raddr;
  logic [NS-1:0] rdata [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    tbk_bank #(.W(NS), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (step_valid && (wr_bank == 1'(g))),
      .waddr (wr_ptr),
      .wdata (surv_word),
      .raddr (raddr),
      .rdata (rdata[g])
    );
  end

  logic push, push_bit, push_last, push_sel;

  tbk_tracer #(.KMAX(KMAX), .DEPTH(DEPTH)) u_tracer (
    .clk         (clk),
    .rst         (rst),
    .start       (blk_end),
    .start_bank  (wr_bank),
    .start_state (start_state),
    .start_k     (k_eff),
    .raddr       (raddr),
    .rdata0      (rdata[0]),
    .rdata1      (rdata[1]),
    .push        (push),
    .push_bit    (push_bit),
    .push_last   (push_last),
    .push_sel    (push_sel)
  );

  // Two stacks, paired with the banks
  logic [1:0] lv, lb;

  for (genvar g = 0; g < 2; g++) begin : g_lifo
    tbk_lifo #(.DEPTH(DEPTH)) u_lifo (
      .clk       (clk),
      .rst       (rst),
      .push      (push && (push_sel == 1'(g))),
      .push_bit  (push_bit),
      .push_last (push_last),
      .out_valid (lv[g]),
      .out_bit   (lb[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= |lv;
      dec_bit   <= lv[1] ? lb[1] : lb[0];
    end
  end

  assert_single_drain_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lv));

endmodule

// File: tb/sim_tbk_survivor_mgr.sv
module sim_tbk_survivor_mgr;
  import tbk_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int KMAX  = 7;
  localparam int DEPTH = 32;
  localparam int SW    = KMAX - 1;
  localparam int NS    = 1 << SW;
  localparam int KW    = $clog2(KMAX + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          step_valid;
  logic [NS-1:0] surv_word;
  logic [SW-1:0] best_state;
  logic [KW-1:0] k_len;
  logic          dec_valid, dec_bit;

  tbk_survivor_mgr #(.KMAX(KMAX), .DEPTH(DEPTH)) u0 (
    .clk, .rst, .step_valid, .surv_word, .best_state, .k_len, .dec_valid, .dec_bit
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // Output monitor
  bit got[$];
  bit exp_q[$];
  int first_cyc, last_cyc, nval = 0;

  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      got.push_back(dec_bit);
      if (nval == 0) first_cyc = cyc;
      last_cyc = cyc;
      nval++;
    end
  end

  logic [SW-1:0] enc = '0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    got.delete();
    exp_q.delete();
    nval = 0;
  endtask

  // Feed one block of DEPTH steps built from a random bit sequence
  task automatic feed_block(int kcode, int keff, int gap, bit noisy_k);
    for (int t = 0; t < DEPTH; t++) begin
      bit            u;
      logic [SW-1:0] mask, prev, best;
      logic [NS-1:0] w;
      u    = 1'($urandom_range(0, 1));
      mask = SW'((1 << (keff - 1)) - 1);
      prev = enc;
      enc  = ((enc << 1) | SW'(u)) & mask;
      w    = {$urandom, $urandom};
      w[enc] = prev[keff-2];
      best = (SW'($urandom) & ~mask) | enc;
      step_valid = 1'b1;
      surv_word  = w;
      best_state = (t == DEPTH - 1) ? best : SW'($urandom);
      k_len      = (t == DEPTH - 1 || !noisy_k) ? KW'(kcode) : KW'($urandom);
      exp_q.push_back(u);
      @(negedge clk);
      step_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        surv_word  = {$urandom, $urandom};
        best_state = SW'($urandom);
        k_len      = KW'($urandom);
        @(negedge clk);
      end
    end
  endtask

  task automatic drain_compare(string req, string tag);
    int bad;
    for (int i = 0; i < 4 * DEPTH + 10 && got.size() < exp_q.size(); i++) @(negedge clk);
    repeat (DEPTH + 5) @(negedge clk);
    check(req, {tag, " bit count"}, got.size(), exp_q.size());
    bad = 0;
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      if (got[i] != exp_q[i]) bad++;
    check(req, {tag, " mismatched bits"}, bad, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1; step_valid = 1'b0; surv_word = '0; best_state = '0; k_len = KW'(7);
    repeat (4) @(negedge clk);
    check("R1", "dec_valid in reset", int'(dec_valid), 0);
    check("R1", "dec_bit in reset", int'(dec_bit), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // R1 quiet first block, R8 latency and burst, R3 R4 values
  task automatic test_first_block();
    int lat;
    clear_mon();
    feed_block(7, 7, 0, 1'b0);
    check("R1", "no output before first block traced", nval, 0);
    lat = 0;
    while (!dec_valid && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check("R8", "edges from final step to first bit", lat, DEPTH + 3);
    drain_compare("R3 R4", "K=7 single block");
    check("R8", "burst span", last_cyc - first_cyc + 1, DEPTH);
  endtask

  task automatic test_gaps();
    clear_mon();
    feed_block(5, 5, 2, 1'b1);
    feed_block(5, 5, 3, 1'b1);
    drain_compare("R2", "gapped K=5 with garbage in idle cycles");
  endtask

  task automatic test_back_to_back();
    clear_mon();
    for (int b = 0; b < 4; b++) feed_block(6, 6, 0, 1'b0);
    drain_compare("R9", "four back-to-back K=6 blocks");
    check("R9", "continuous output span", last_cyc - first_cyc + 1, nval);
    check("R9", "total bits", nval, 4 * DEPTH);
  endtask

  task automatic test_k_switch();
    clear_mon();
    feed_block(3, 3, 0, 1'b1);
    feed_block(7, 7, 0, 1'b1);
    feed_block(4, 4, 0, 1'b1);
    drain_compare("R6", "K 3 then 7 then 4");
  endtask

  task automatic test_small_k();
    clear_mon();
    feed_block(3, 3, 1, 1'b0);
    drain_compare("R5", "K=3 with garbage upper word and state bits");
  endtask

  task automatic test_clamp();
    clear_mon();
    feed_block(0, 3, 0, 1'b0);
    feed_block(2, 3, 0, 1'b0);
    drain_compare("R7", "k_len 0 and 2 act as K=3");
  endtask

  task automatic test_reset_mid();
    for (int t = 0; t < DEPTH / 2; t++) begin
      step_valid = 1'b1; surv_word = {$urandom, $urandom};
      best_state = SW'($urandom); k_len = KW'(5);
      @(negedge clk);
    end
    step_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_mon();
    repeat (3 * DEPTH) @(negedge clk);
    check("R1", "partial block before reset yields nothing", nval, 0);
    feed_block(5, 5, 0, 1'b0);
    drain_compare("R1", "first block after mid-run reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_first_block();
    test_gaps();
    test_back_to_back();
    test_k_switch();
    test_small_k();
    test_clamp();
    test_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule